// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Rotator

This block computes the sine and cosine of a signed fixed-point angle in radians. It uses rotation-mode CORDIC with one shift-and-add micro-rotation per clock. A single accepted `start` pulse latches the angle and an iteration-count code. The engine then steps through the selected number of micro-rotations and raises `done` for one cycle. At that point `cos_out` and `sin_out` carry the results, and they keep those values until the next accepted start.

The x register is preloaded with the reciprocal of the accumulated rotation gain for the chosen iteration count, so no multiplier follows the iterations. A quarter-turn fold on entry maps any angle in [−π, +π] into the converging range [−π/2, +π/2] and adds no gain. The arctangent constants and the gain reciprocals are computed at elaboration for the chosen widths. A caller trades latency for precision by picking 5, 10, 15 or 20 steps per request.

Top module: `cordic_sincos`

## Requirements
- R1: `angle` is two's complement radians with 23 fractional bits. `cos_out` and `sin_out` are two's complement with 22 fractional bits. With 20 iterations, both outputs are within 4e-6 of the true cosine and sine for every angle in [−π, +π].
- R2: `iter_sel` is sampled only with an accepted start and codes the iteration count: 0 gives 5, 1 gives 10, 2 gives 15 and 3 gives 20. `done` rises exactly N clock edges after the edge that accepts `start`.
- R3: With 5, 10 or 15 iterations, each output is within 2^-(N-1) + 2e-5 of the true value.
- R4: Angles beyond ±π/2 are folded by a quarter turn before iterating, so the residual angle loaded at start never exceeds π/2 in magnitude (two LSBs of slack). An angle of π yields cosine ≈ −1 and sine ≈ 0.
- R5: Each step rotates in the negative direction when the residual angle is negative and in the positive direction otherwise. When `done` is high, the residual magnitude is at most twice the arctangent of 2^-N plus N angle LSBs.
- R6: A `start` that arrives while the engine is busy is ignored, together with the `angle` and `iter_sel` that come with it. The run in progress keeps its count and its result.
- R7: `done` is high for exactly one cycle. After it, `cos_out` and `sin_out` stay constant until the next accepted start.
- R8: While reset is held and after it is released, `done` is low and both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only when idle |
| angle | input | ANG_W (26) | Signed angle in radians, ANG_FRAC fractional bits |
| iter_sel | input | 2 | Iteration-count code (5, 10, 15, 20) |
| cos_out | output | OUT_W (24) | Signed cosine, OUT_FRAC fractional bits |
| sin_out | output | OUT_W (24) | Signed sine, OUT_FRAC fractional bits |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-RTL properties check, on every cycle, the following:
- the one-cycle width of `done`;
- that the step counter advances by one per busy cycle whatever `start` does;
- that the outputs hold while idle;
- that the folded residual starts within a quarter turn;
- that the residual angle has converged to the bound for its count when `done` rises.

Numerical accuracy against true sine and cosine, the exact latency per iteration code, and the fact that an ignored mid-run request leaves the first result untouched are shown only by the bench's directed and seeded-random scenarios.

// File: rtl/cordic_pkg.sv
`timescale 1ns/1ps
package cordic_pkg;

   // Fractional bits of the elaboration-time reference arithmetic
   localparam int FX = 60;

   typedef logic [1:0] iter_code_t;

   // atan(1/q) in FX fractional bits, alternating power series
   function automatic longint atan_recip(input longint q);
      longint p;
      longint s;
      s = 0;
      p = (64'sd1 <<< FX) / q;
      for (int j = 0; j < 40; j++) begin
         if (j % 2 == 0) s = s + p / longint'(2 * j + 1);
         else            s = s - p / longint'(2 * j + 1);
         p = p / (q * q);
      end
      return s;
   endfunction

   // atan(2^-i) in FX fractional bits; i = 0 uses Machin's identity
   function automatic longint atan_fx(input int i);
      if (i == 0) return 4 * atan_recip(64'sd5) - atan_recip(64'sd239);
      return atan_recip(64'sd1 <<< i);
   endfunction

   // rounding requantisation from src to dst fractional bits (src > dst)
   function automatic longint fx_round(input longint v, input int src, input int dst);
      return (v + (64'sd1 <<< (src - dst - 1))) >>> (src - dst);
   endfunction

   // integer square root, bit-pair method
   function automatic longint isqrt(input longint v);
      longint num;
      longint res;
      longint b;
      num = v;
      res = 0;
      for (int k = 31; k >= 0; k--) begin
         b = 64'sd1 <<< (2 * k);
         if (num >= res + b) begin
            num = num - res - b;
            res = (res >>> 1) + b;
         end else begin
            res = res >>> 1;
         end
      end
      return res;
   endfunction

   // 1 / prod sqrt(1 + 4^-i) over n steps, in frac fractional bits (frac < 30)
   function automatic longint gain_recip_fx(input int n, input int frac);
      longint k2;
      longint d;
      longint q;
      longint r;
      k2 = 64'sd1 <<< FX;
      for (int i = 0; i < n; i++) begin
         if (i <= 14) begin
            d  = (64'sd1 <<< (2 * i)) + 1;
            q  = k2 / d;
            r  = k2 % d;
            k2 = (q <<< (2 * i)) + ((r <<< (2 * i)) / d);
         end
      end
      return fx_round(isqrt(k2), FX / 2, frac);
   endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
`timescale 1ns/1ps
module cordic_atan_rom
   import cordic_pkg::*;
#(
   parameter int ANG_W    = 26,
   parameter int ANG_FRAC = 23,
   parameter int DEPTH    = 21,
   parameter int IDX_W    = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]        idx,
   output logic signed [ANG_W-1:0] atan_val
);

   logic signed [ANG_W-1:0] tbl [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         localparam longint AV = fx_round(atan_fx(g), FX, ANG_FRAC);
         assign tbl[g] = AV[ANG_W-1:0];
      end
   endgenerate

   always_comb begin
      atan_val = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (idx == IDX_W'(k)) atan_val = tbl[k];
      end
   end

endmodule

// File: rtl/cordic_quad_fold.sv
`timescale 1ns/1ps
module cordic_quad_fold
   import cordic_pkg::*;
#(
   parameter int XY_W     = 28,
   parameter int ANG_W    = 26,
   parameter int ANG_FRAC = 23
) (
   input  logic signed [ANG_W-1:0] ang,
   input  logic signed [XY_W-1:0]  x_init,
   output logic signed [XY_W-1:0]  x0,
   output logic signed [XY_W-1:0]  y0,
   output logic signed [ANG_W-1:0] z0
);

   localparam longint HP = fx_round(2 * atan_fx(0), FX, ANG_FRAC);
   localparam logic signed [ANG_W-1:0] HALF = HP[ANG_W-1:0];

   // quarter-turn pre-rotation: (k,0) turned by +/-pi/2 becomes (0,+/-k)
   always_comb begin
      x0 = x_init;
      y0 = '0;
      z0 = ang;
      if (ang > HALF) begin
         x0 = '0;
         y0 = x_init;
         z0 = ang - HALF;
      end else if (ang < -HALF) begin
         x0 = '0;
         y0 = -x_init;
         z0 = ang + HALF;
      end
   end

endmodule

// File: rtl/cordic_microrot.sv
`timescale 1ns/1ps
module cordic_microrot #(
   parameter int XY_W  = 28,
   parameter int ANG_W = 26,
   parameter int SH_W  = 5
) (
   input  logic signed [XY_W-1:0]  x_in,
   input  logic signed [XY_W-1:0]  y_in,
   input  logic signed [ANG_W-1:0] z_in,
   input  logic [SH_W-1:0]         shift,
   input  logic signed [ANG_W-1:0] atan_val,
   output logic signed [XY_W-1:0]  x_out,
   output logic signed [XY_W-1:0]  y_out,
   output logic signed [ANG_W-1:0] z_out
);

   logic signed [XY_W-1:0] xs;
   logic signed [XY_W-1:0] ys;

   assign xs = x_in >>> shift;
   assign ys = y_in >>> shift;

   always_comb begin
      if (z_in[ANG_W-1]) begin
         x_out = x_in + ys;
         y_out = y_in - xs;
         z_out = z_in + atan_val;
      end else begin
         x_out = x_in - ys;
         y_out = y_in + xs;
         z_out = z_in - atan_val;
      end
   end

endmodule

// File: rtl/cordic_sincos.sv
`timescale 1ns/1ps
module cordic_sincos
   import cordic_pkg::*;
#(
   parameter int ANG_W     = 26,
   parameter int ANG_FRAC  = 23,
   parameter int OUT_W     = 24,
   parameter int OUT_FRAC  = 22,
   parameter int GFRAC     = 3,
   parameter int ITER_STEP = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [ANG_W-1:0] angle,
   input  logic [1:0]              iter_sel,
   output logic signed [OUT_W-1:0] cos_out,
   output logic signed [OUT_W-1:0] sin_out,
   output logic                    done
);

   localparam int XY_W     = OUT_W + GFRAC + 1;
   localparam int XY_FRAC  = OUT_FRAC + GFRAC;
   localparam int MAX_ITER = 4 * ITER_STEP;
   localparam int ROM_D    = MAX_ITER + 1;
   localparam int IDX_W    = $clog2(ROM_D);
   localparam logic signed [XY_W-1:0] RND = XY_W'(1) <<< (GFRAC - 1);
   localparam longint HP = fx_round(2 * atan_fx(0), FX, ANG_FRAC);
   localparam logic [ANG_W-1:0] HALF_U = HP[ANG_W-1:0];

   generate
      if (ANG_W - ANG_FRAC < 3) begin : g_bad_ang
         $error("angle needs three integer bits to hold +/-pi");
      end
      if (OUT_W - OUT_FRAC < 2) begin : g_bad_out
         $error("outputs need two integer bits");
      end
      if (GFRAC < 1 || XY_FRAC >= 30) begin : g_bad_guard
         $error("guard bits out of range");
      end
      if (MAX_ITER > 30 || ITER_STEP < 1) begin : g_bad_iter
         $error("iteration count out of range");
      end
   endgenerate

   // gain-reciprocal preload per iteration code
   logic signed [XY_W-1:0] kpre [4];
   generate
      for (genvar g = 0; g < 4; g++) begin : g_gain
         localparam longint KV = gain_recip_fx(ITER_STEP * (g + 1), XY_FRAC);
         assign kpre[g] = KV[XY_W-1:0];
      end
   endgenerate

   logic signed [XY_W-1:0]  x_q, y_q, x_n, y_n, x0, y0;
   logic signed [ANG_W-1:0] z_q, z_n, z0, atan_cur;
   logic [IDX_W-1:0]        cnt_q, last_q, last_d;
   logic                    busy_q, done_q;

   assign last_d = IDX_W'(ITER_STEP * (int'(iter_sel) + 1) - 1);

   cordic_quad_fold #(.XY_W(XY_W), .ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC)) u_fold (
      .ang(angle), .x_init(kpre[iter_sel]), .x0(x0), .y0(y0), .z0(z0)
   );

   cordic_atan_rom #(.ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC), .DEPTH(ROM_D), .IDX_W(IDX_W)) u_rom (
      .idx(cnt_q), .atan_val(atan_cur)
   );

   cordic_microrot #(.XY_W(XY_W), .ANG_W(ANG_W), .SH_W(IDX_W)) u_rot (
      .x_in(x_q), .y_in(y_q), .z_in(z_q), .shift(cnt_q), .atan_val(atan_cur),
      .x_out(x_n), .y_out(y_n), .z_out(z_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         cnt_q  <= '0;
         last_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            x_q   <= x_n;
            y_q   <= y_n;
            z_q   <= z_n;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (start) begin
            x_q    <= x0;
            y_q    <= y0;
            z_q    <= z0;
            cnt_q  <= '0;
            last_q <= last_d;
            busy_q <= 1'b1;
         end
      end
   end

   logic signed [XY_W-1:0] xr, yr;
   assign xr      = x_q + RND;
   assign yr      = y_q + RND;
   assign cos_out = xr[GFRAC +: OUT_W];
   assign sin_out = yr[GFRAC +: OUT_W];
   assign done    = done_q;

   // ---------------- assertions ----------------
   function automatic logic [ANG_W-1:0] mag(input logic signed [ANG_W-1:0] v);
      return v[ANG_W-1] ? ANG_W'(-v) : ANG_W'(v);
   endfunction

   logic [ANG_W:0] res_bound;
   assign res_bound = {atan_cur, 1'b0} + (ANG_W+1)'(MAX_ITER);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> ($stable(cos_out) && $stable(sin_out)));

   // R6
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != last_q) |=> (busy_q && cnt_q == IDX_W'($past(cnt_q) + 1'b1)));

   // R4
   fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ({1'b0, mag(z_q)} <= {1'b0, HALF_U} + (ANG_W+1)'(2)));

   // R5
   residual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ({1'b0, mag(z_q)} <= res_bound));

endmodule

// File: tb/sim_cordic_sincos.sv
`timescale 1ns/1ps
module sim_cordic_sincos;

   localparam int  AW = 26;
   localparam int  AF = 23;
   localparam int  OW = 24;
   localparam int  OF = 22;
   localparam real PI = 3.14159265358979;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic signed [AW-1:0] angle = '0;
   logic [1:0]           iter_sel = '0;
   logic signed [OW-1:0] cos_out;
   logic signed [OW-1:0] sin_out;
   logic                 done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cordic_sincos u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .angle(angle),
      .iter_sel(iter_sel), .cos_out(cos_out), .sin_out(sin_out), .done(done)
   );

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   function automatic logic signed [AW-1:0] to_code(input real r);
      return AW'($rtoi(r * 2.0**AF + ((r >= 0.0) ? 0.5 : -0.5)));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%.8f expected=%.8f", req, what, act, exp);
      end
   endtask

   // one request; poke injects an ignored start mid-run (R6)
   task automatic run(input logic signed [AW-1:0] a, input logic [1:0] s, input bit poke);
      int    n;
      int    cyc;
      real   ar, ec, es, gc, gs, tol;
      string req;
      logic signed [OW-1:0] hc, hs;
      n   = 5 * (int'(s) + 1);
      cyc = 0;
      @(negedge clk);
      angle = a; iter_sel = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (1'b1) begin
         @(negedge clk);
         cyc++;
         start = poke && (cyc == 2);
         if (start) begin
            angle = -a;
            iter_sel = ~s;
         end
         if (done || cyc > 60) break;
      end
      start = 1'b0;
      ar  = real'(a) / 2.0**AF;
      ec  = $cos(ar);
      es  = $sin(ar);
      gc  = real'(cos_out) / 2.0**OF;
      gs  = real'(sin_out) / 2.0**OF;
      tol = (n == 20) ? 4.0e-6 : (2.0**(-(n - 1)) + 2.0e-5);
      req = (n == 20) ? "R1,R5" : "R3";
      if (rabs(ar) > PI / 2.0) req = {req, ",R4"};
      if (poke) req = {req, ",R6"};
      chk(cyc == n, poke ? "R2,R6" : "R2", "latency", real'(cyc), real'(n));
      chk(rabs(gc - ec) <= tol, req, "cosine", gc, ec);
      chk(rabs(gs - es) <= tol, req, "sine", gs, es);
      hc = cos_out;
      hs = sin_out;
      @(negedge clk);
      chk(done == 1'b0, "R7", "done width", real'(done), 0.0);
      repeat (2) @(negedge clk);
      chk(cos_out == hc, "R7", "cosine hold", real'(cos_out), real'(hc));
      chk(sin_out == hs, "R7", "sine hold", real'(sin_out), real'(hs));
   endtask

   initial begin
      int unsigned seed0;
      int          pcode;
      seed0 = $urandom(32'd20250611);
      pcode = int'(to_code(PI));
      repeat (2) @(negedge clk);
      // R8 during reset
      chk(done == 1'b0 && cos_out == 0 && sin_out == 0, "R8", "in reset",
          real'(cos_out), 0.0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R8", "done after reset", real'(done), 0.0);
      chk(cos_out == 0 && sin_out == 0, "R8", "outputs after reset",
          real'(sin_out), 0.0);

      // directed corners
      run(to_code(0.0), 2'd3, 1'b0);
      run(to_code(PI / 6.0), 2'd3, 1'b0);
      run(to_code(1.0), 2'd3, 1'b0);
      run(to_code(PI), 2'd3, 1'b0);               // R4: cos -1, sin 0
      run(to_code(-PI), 2'd3, 1'b0);
      run(to_code(PI / 2.0), 2'd3, 1'b0);
      run(to_code(PI / 2.0) + 1, 2'd3, 1'b0);
      run(to_code(-PI / 2.0) - 1, 2'd3, 1'b0);
      run(to_code(PI), 2'd0, 1'b0);               // R3 with each short count
      run(to_code(1.0), 2'd0, 1'b0);
      run(to_code(2.5), 2'd1, 1'b0);
      run(to_code(-2.0), 2'd2, 1'b0);
      // R6: start during a run is ignored
      run(to_code(0.7), 2'd3, 1'b1);
      run(to_code(-2.9), 2'd1, 1'b1);

      // constrained random over [-pi, pi]
      for (int t = 0; t < 40; t++) begin
         int unsigned r;
         logic signed [AW-1:0] a;
         r = $urandom % (2 * pcode + 1);
         a = AW'(int'(r) - pcode);
         run(a, 2'($urandom % 4), 1'b0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule